// File: doc/BRIEF.md
# Temperature Register Remap for Legacy Layout

This block sits on the path between a byte-wide register bus and the temperature register file behind it. When the legacy layout switch is on, software that was written for a part with a diode-based first remote channel finds the data of the first digital thermal channel at the old remote-channel addresses, and the reverse. Whole registers trade places. So do some sub-fields that share a byte with unrelated settings, and the two hysteresis bytes, whose nibbles change position on the way. Stored data is never converted. A byte that is written lands in its physical home unchanged apart from that steering.

Each bus access is split over two physical ports, A and B. Each port carries an address, a per-bit write mask and write data, and returns read data. A shared register can therefore be read or written partly in one physical byte and partly in another in the same access, with no added cycle. The register file applies the per-bit write masks. The block also reports, for each PWM output, whether the digital channel takes over control of that output. This happens in legacy layout when the output's behaviour field holds its default value.

Top module: `temp_remap`

## Requirements
- R1: With `replace_en` low, port A addresses the bus address with all lanes enabled, port B enables no lane, and read data equals the addressed physical byte.
- R2: With `replace_en` high, these address pairs exchange as whole bytes in both directions: 0x25/0x33, 0x4E/0x34, 0x4F/0x35, 0x67/0x3B, 0x6A/0x3D, 0x70/0x94, 0x8B/0x8A.
- R3: With `replace_en` high, logical 0x6D maps to physical 0x6E and logical 0x6E maps to physical 0x6D, with the upper and lower nibbles exchanged on both reads and writes.
- R4: With `replace_en` high, logical 0x5F = {phys 0x3C[7:4], phys 0x5F[3:0]}. Logical 0x3C = {phys 0x5F[7:4], phys 0x62[3:0]}. Logical 0x62 = {phys 0x62[7:4], phys 0x3C[3:0]}.
- R5: A write to a shared register in legacy layout sets write-mask bits only in the physical bits it owns, so the other bits of each physical byte keep their values.
- R6: Addresses outside the swap set pass through unchanged when `replace_en` is high (for example 0x10 and the mode byte 0x36).
- R7: The written byte reaches the physical byte unaltered, with no format conversion.
- R8: With `bus_rd` low, `bus_rdata` is zero. With `bus_wr` low, both write masks are zero.
- R9: `pwm_peci_zone[i]` is high exactly when `replace_en` is high and `pwm_behav[3*i+2:3*i]` equals 000.
- R10: Translation is combinational. A change of `replace_en` applies to the very next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| replace_en | input | 1 | Legacy layout switch (mode bit held in the register file) |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 8 | Logical register address |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data, zero when not reading |
| rf_a_addr | output | 8 | Port A physical address |
| rf_a_wmask | output | 8 | Port A per-bit write enable |
| rf_a_wdata | output | 8 | Port A write data |
| rf_a_rdata | input | 8 | Port A physical read data |
| rf_b_addr | output | 8 | Port B physical address |
| rf_b_wmask | output | 8 | Port B per-bit write enable |
| rf_b_wdata | output | 8 | Port B write data |
| rf_b_rdata | input | 8 | Port B physical read data |
| pwm_behav | input | 3*NUM_PWM | Behaviour field of each PWM output, 3 bits each |
| pwm_peci_zone | output | NUM_PWM | High when the digital channel controls that output |

## Verification
The bench builds the block with its default of three PWM outputs and 8-bit address and data paths. Three outputs let one run mix default and non-default behaviour fields, and show that the zone takeover is decided per output. With the full 8-bit address space, the bench's register-file model can hold every physical byte with a distinct pattern. Each shared-register read then shows which nibble came from which byte, and each partial write shows which bits stayed untouched.

// File: rtl/temp_remap_pkg.sv
package temp_remap_pkg;
  localparam int unsigned RA_W = 8;
  localparam int unsigned RD_W = 8;
  localparam int unsigned HALF = RD_W / 2;
  localparam int unsigned NPAIR = 7;

  localparam logic [RD_W-1:0] LANE_ALL = {RD_W{1'b1}};
  localparam logic [RD_W-1:0] LANE_NONE = {RD_W{1'b0}};
  localparam logic [RD_W-1:0] LANE_HI = {{HALF{1'b1}}, {HALF{1'b0}}};
  localparam logic [RD_W-1:0] LANE_LO = {{HALF{1'b0}}, {HALF{1'b1}}};

  // whole-byte exchange pairs: legacy side and digital-channel side, same index
  localparam logic [NPAIR*RA_W-1:0] LEGACY_SET =
    {8'h8B, 8'h70, 8'h6A, 8'h67, 8'h4F, 8'h4E, 8'h25};
  localparam logic [NPAIR*RA_W-1:0] DIGITAL_SET =
    {8'h8A, 8'h94, 8'h3D, 8'h3B, 8'h35, 8'h34, 8'h33};

  // hysteresis bytes, exchanged with nibble rotation
  localparam logic [RA_W-1:0] HYST_LO_ADDR = 8'h6D;
  localparam logic [RA_W-1:0] HYST_HI_ADDR = 8'h6E;

  // shared bytes holding swapped sub-fields
  localparam logic [RA_W-1:0] SH_RANGE_ADDR = 8'h5F;
  localparam logic [RA_W-1:0] SH_DIGCFG_ADDR = 8'h3C;
  localparam logic [RA_W-1:0] SH_ACOUST_ADDR = 8'h62;

  typedef struct packed {
    logic [RA_W-1:0] a_addr;
    logic [RD_W-1:0] a_lane;
    logic            a_rot;
    logic [RA_W-1:0] b_addr;
    logic [RD_W-1:0] b_lane;
    logic            b_rot;
  } route_t;

  function automatic logic [RD_W-1:0] swap_halves(input logic [RD_W-1:0] v);
    return {v[HALF-1:0], v[RD_W-1:HALF]};
  endfunction

  function automatic logic [RD_W-1:0] steer(input logic [RD_W-1:0] v, input logic rot);
    return rot ? swap_halves(v) : v;
  endfunction

  // route for bytes with sub-field sharing; whole-byte and pass-through cases elsewhere
  function automatic route_t shared_route(input logic [RA_W-1:0] addr, input route_t dflt);
    route_t r;
    r = dflt;
    if (addr == SH_RANGE_ADDR) begin
      r.a_addr = SH_RANGE_ADDR;  r.a_lane = LANE_LO; r.a_rot = 1'b0;
      r.b_addr = SH_DIGCFG_ADDR; r.b_lane = LANE_HI; r.b_rot = 1'b0;
    end else if (addr == SH_DIGCFG_ADDR) begin
      r.a_addr = SH_ACOUST_ADDR; r.a_lane = LANE_LO; r.a_rot = 1'b0;
      r.b_addr = SH_RANGE_ADDR;  r.b_lane = LANE_HI; r.b_rot = 1'b0;
    end else if (addr == SH_ACOUST_ADDR) begin
      r.a_addr = SH_ACOUST_ADDR; r.a_lane = LANE_HI; r.a_rot = 1'b0;
      r.b_addr = SH_DIGCFG_ADDR; r.b_lane = LANE_LO; r.b_rot = 1'b0;
    end
    return r;
  endfunction
endpackage

// File: rtl/temp_remap_route.sv
module temp_remap_route
  import temp_remap_pkg::*;
(
  input  logic            replace_en,
  input  logic [RA_W-1:0] bus_addr,
  output route_t          route
);
  logic [NPAIR-1:0] hit_legacy;
  logic [NPAIR-1:0] hit_digital;
  logic             hit_pair;
  logic [RA_W-1:0]  partner;
  logic             hit_hyst;
  logic [RA_W-1:0]  hyst_partner;
  route_t           base;

  for (genvar gi = 0; gi < NPAIR; gi++) begin : g_pair
    assign hit_legacy[gi]  = (bus_addr == LEGACY_SET[gi*RA_W +: RA_W]);
    assign hit_digital[gi] = (bus_addr == DIGITAL_SET[gi*RA_W +: RA_W]);
  end

  assign hit_pair = |{hit_legacy, hit_digital};
  assign hit_hyst = (bus_addr == HYST_LO_ADDR) || (bus_addr == HYST_HI_ADDR);
  assign hyst_partner = (bus_addr == HYST_LO_ADDR) ? HYST_HI_ADDR : HYST_LO_ADDR;

  always_comb begin
    partner = bus_addr;
    for (int i = 0; i < NPAIR; i++) begin
      if (hit_legacy[i])  partner = DIGITAL_SET[i*RA_W +: RA_W];
      if (hit_digital[i]) partner = LEGACY_SET[i*RA_W +: RA_W];
    end
  end

  always_comb begin
    base.a_addr = bus_addr;
    base.a_lane = LANE_ALL;
    base.a_rot  = 1'b0;
    base.b_addr = bus_addr;
    base.b_lane = LANE_NONE;
    base.b_rot  = 1'b0;
    route = base;
    if (replace_en) begin
      if (hit_pair) begin
        route.a_addr = partner;
      end else if (hit_hyst) begin
        route.a_addr = hyst_partner;
        route.a_rot  = 1'b1;
      end else begin
        route = shared_route(bus_addr, base);
      end
    end
  end

  // R4 R5: the two ports together cover every logical bit exactly once
  always_comb begin
    a_r4_lanes_disjoint: assert ((route.a_lane & route.b_lane) == LANE_NONE)
      else $error("lanes overlap");
    a_r5_lanes_cover: assert ((route.a_lane | route.b_lane) == LANE_ALL)
      else $error("lanes leave a gap");
  end
endmodule

// File: rtl/temp_remap_steer.sv
module temp_remap_steer
  import temp_remap_pkg::*;
(
  input  route_t          route,
  input  logic            bus_rd,
  input  logic            bus_wr,
  input  logic [RD_W-1:0] bus_wdata,
  output logic [RD_W-1:0] bus_rdata,
  output logic [RA_W-1:0] rf_a_addr,
  output logic [RD_W-1:0] rf_a_wmask,
  output logic [RD_W-1:0] rf_a_wdata,
  input  logic [RD_W-1:0] rf_a_rdata,
  output logic [RA_W-1:0] rf_b_addr,
  output logic [RD_W-1:0] rf_b_wmask,
  output logic [RD_W-1:0] rf_b_wdata,
  input  logic [RD_W-1:0] rf_b_rdata
);
  logic [RD_W-1:0] a_view;
  logic [RD_W-1:0] b_view;
  logic [RD_W-1:0] merged;

  assign rf_a_addr  = route.a_addr;
  assign rf_b_addr  = route.b_addr;
  assign rf_a_wdata = steer(bus_wdata, route.a_rot);
  assign rf_b_wdata = steer(bus_wdata, route.b_rot);
  assign rf_a_wmask = bus_wr ? steer(route.a_lane, route.a_rot) : LANE_NONE;
  assign rf_b_wmask = bus_wr ? steer(route.b_lane, route.b_rot) : LANE_NONE;

  assign a_view = steer(rf_a_rdata, route.a_rot) & route.a_lane;
  assign b_view = steer(rf_b_rdata, route.b_rot) & route.b_lane;
  assign merged = a_view | b_view;
  assign bus_rdata = bus_rd ? merged : LANE_NONE;

  always_comb begin
    if (!bus_wr) begin
      a_r8_no_stray_write: assert (rf_a_wmask == LANE_NONE && rf_b_wmask == LANE_NONE)
        else $error("write mask without write strobe");
    end
    if (!bus_rd) begin
      a_r8_quiet_read: assert (bus_rdata == LANE_NONE)
        else $error("read data without read strobe");
    end
    if (bus_wr && route.a_addr == route.b_addr) begin
      a_r5_single_byte_mask: assert (rf_b_wmask == LANE_NONE)
        else $error("port B writes the same byte as port A");
    end
  end
endmodule

// File: rtl/temp_remap_zone.sv
module temp_remap_zone #(
  parameter int unsigned NUM_PWM = 3,
  parameter int unsigned BEH_W   = 3
) (
  input  logic                     replace_en,
  input  logic [NUM_PWM*BEH_W-1:0] pwm_behav,
  output logic [NUM_PWM-1:0]       pwm_peci_zone
);
  for (genvar gp = 0; gp < NUM_PWM; gp++) begin : g_out
    logic is_default;
    assign is_default = (pwm_behav[gp*BEH_W +: BEH_W] == '0);
    assign pwm_peci_zone[gp] = replace_en && is_default;

    always_comb begin
      if (pwm_peci_zone[gp]) begin
        a_r9_takeover_needs_default: assert (replace_en && pwm_behav[gp*BEH_W +: BEH_W] == '0)
          else $error("zone takeover on a non-default output");
      end
    end
  end
endmodule

// File: rtl/temp_remap.sv
module temp_remap
  import temp_remap_pkg::*;
#(
  parameter int unsigned NUM_PWM = 3,
  parameter int unsigned BEH_W   = 3
) (
  input  logic                     replace_en,
  input  logic                     bus_rd,
  input  logic                     bus_wr,
  input  logic [RA_W-1:0]          bus_addr,
  input  logic [RD_W-1:0]          bus_wdata,
  output logic [RD_W-1:0]          bus_rdata,
  output logic [RA_W-1:0]          rf_a_addr,
  output logic [RD_W-1:0]          rf_a_wmask,
  output logic [RD_W-1:0]          rf_a_wdata,
  input  logic [RD_W-1:0]          rf_a_rdata,
  output logic [RA_W-1:0]          rf_b_addr,
  output logic [RD_W-1:0]          rf_b_wmask,
  output logic [RD_W-1:0]          rf_b_wdata,
  input  logic [RD_W-1:0]          rf_b_rdata,
  input  logic [NUM_PWM*BEH_W-1:0] pwm_behav,
  output logic [NUM_PWM-1:0]       pwm_peci_zone
);
  route_t route;

  temp_remap_route u_route (
    .replace_en (replace_en),
    .bus_addr   (bus_addr),
    .route      (route)
  );

  temp_remap_steer u_steer (
    .route      (route),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .rf_a_addr  (rf_a_addr),
    .rf_a_wmask (rf_a_wmask),
    .rf_a_wdata (rf_a_wdata),
    .rf_a_rdata (rf_a_rdata),
    .rf_b_addr  (rf_b_addr),
    .rf_b_wmask (rf_b_wmask),
    .rf_b_wdata (rf_b_wdata),
    .rf_b_rdata (rf_b_rdata)
  );

  temp_remap_zone #(.NUM_PWM(NUM_PWM), .BEH_W(BEH_W)) u_zone (
    .replace_en    (replace_en),
    .pwm_behav     (pwm_behav),
    .pwm_peci_zone (pwm_peci_zone)
  );

  always_comb begin
    if (!replace_en) begin
      a_r1_identity_port_a: assert (rf_a_addr == bus_addr && rf_b_wmask == LANE_NONE)
        else $error("remap active while legacy layout is off");
      a_r9_no_takeover_off: assert (pwm_peci_zone == '0)
        else $error("zone takeover while legacy layout is off");
    end
    if (bus_wr && !replace_en) begin
      a_r7_data_verbatim: assert (rf_a_wdata == bus_wdata && rf_a_wmask == LANE_ALL)
        else $error("write data altered");
    end
  end
endmodule

// File: tb/temp_remap_test.sv
`timescale 1ns/1ps
module temp_remap_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       replace_en = 1'b0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] rf_a_addr, rf_a_wmask, rf_a_wdata, rf_a_rdata;
  logic [7:0] rf_b_addr, rf_b_wmask, rf_b_wdata, rf_b_rdata;
  logic [8:0] pwm_behav = 9'h0;
  logic [2:0] pwm_peci_zone;

  logic [7:0] mem [256];
  assign rf_a_rdata = mem[rf_a_addr];
  assign rf_b_rdata = mem[rf_b_addr];

  int total = 0;
  int bad = 0;

  temp_remap uut (
    .replace_en(replace_en), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rf_a_addr(rf_a_addr), .rf_a_wmask(rf_a_wmask), .rf_a_wdata(rf_a_wdata),
    .rf_a_rdata(rf_a_rdata),
    .rf_b_addr(rf_b_addr), .rf_b_wmask(rf_b_wmask), .rf_b_wdata(rf_b_wdata),
    .rf_b_rdata(rf_b_rdata),
    .pwm_behav(pwm_behav), .pwm_peci_zone(pwm_peci_zone)
  );

  // vector: {mode, logical address, expected read}; memory holds addr ^ 8'hA5
  localparam int NV = 18;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 8'h25, 8'h80},  // R1 identity
    {1'b1, 8'h25, 8'h96},  // R2 legacy side reads digital byte
    {1'b1, 8'h33, 8'h80},  // R2 reverse direction
    {1'b0, 8'h33, 8'h96},  // R10 mode dropped on next access
    {1'b1, 8'h4F, 8'h90},  // R2
    {1'b1, 8'h67, 8'h9E},  // R2
    {1'b1, 8'h3D, 8'hCF},  // R2
    {1'b1, 8'h8A, 8'h2E},  // R2
    {1'b1, 8'h94, 8'hD5},  // R2
    {1'b1, 8'h6D, 8'hBC},  // R3 nibbles exchanged
    {1'b1, 8'h6E, 8'h8C},  // R3
    {1'b1, 8'h5F, 8'h9A},  // R4
    {1'b1, 8'h3C, 8'hF7},  // R4
    {1'b1, 8'h62, 8'hC9},  // R4
    {1'b0, 8'h3C, 8'h99},  // R1 shared byte untouched when off
    {1'b0, 8'h5F, 8'hFA},  // R1
    {1'b1, 8'h10, 8'hB5},  // R6 outside the set
    {1'b1, 8'h36, 8'h93}   // R6 mode byte itself
  };

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic m, input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    replace_en = m; bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic do_write(input logic m, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    replace_en = m; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    #1;
    mem[rf_a_addr] = (mem[rf_a_addr] & ~rf_a_wmask) | (rf_a_wdata & rf_a_wmask);
    mem[rf_b_addr] = (mem[rf_b_addr] & ~rf_b_wmask) | (rf_b_wdata & rf_b_wmask);
    #1 bus_wr = 1'b0;
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;

    // idle state at start: no read data, no write masks
    @(negedge clk); #1;
    check8("R8 idle rdata", bus_rdata, 8'h00);
    check8("R8 idle mask a", rf_a_wmask, 8'h00);
    check8("R8 idle mask b", rf_b_wmask, 8'h00);

    for (int v = 0; v < NV; v++) begin
      do_read(VEC[v][16], VEC[v][15:8], rd);
      check8($sformatf("R1/R2/R3/R4/R6/R10 vec %0d", v), rd, VEC[v][7:0]);
    end

    // R8: legacy layout on, write strobe low, no memory change
    @(negedge clk);
    replace_en = 1'b1; bus_addr = 8'h5F; bus_wdata = 8'hFF; #1;
    check8("R8 no mask a when idle", rf_a_wmask, 8'h00);
    check8("R8 no mask b when idle", rf_b_wmask, 8'h00);
    check8("R8 no rdata when idle", bus_rdata, 8'h00);

    // R5: shared byte write keeps untouched bits
    do_write(1'b1, 8'h5F, 8'h3C);
    check8("R5 phys 5F", mem[8'h5F], 8'hFC);
    check8("R5 phys 3C", mem[8'h3C], 8'h39);
    do_write(1'b1, 8'h62, 8'h0A);
    check8("R5 phys 62", mem[8'h62], 8'h07);
    check8("R5 phys 3C second", mem[8'h3C], 8'h3A);

    // R3: hysteresis write lands rotated in the partner byte
    do_write(1'b1, 8'h6D, 8'h12);
    check8("R3 phys 6E", mem[8'h6E], 8'h21);
    check8("R3 phys 6D kept", mem[8'h6D], 8'hC8);

    // R7 and R2: verbatim storage in the right byte
    do_write(1'b0, 8'h25, 8'h55);
    check8("R7 phys 25", mem[8'h25], 8'h55);
    check8("R7 phys 33 kept", mem[8'h33], 8'h96);
    do_write(1'b1, 8'h25, 8'h77);
    check8("R2 phys 33", mem[8'h33], 8'h77);
    check8("R2 phys 25 kept", mem[8'h25], 8'h55);
    do_read(1'b1, 8'h33, rd);
    check8("R10 read back after toggles", rd, 8'h55);

    // R9: zone takeover per output
    @(negedge clk);
    pwm_behav = {3'b000, 3'b001, 3'b000};
    replace_en = 1'b1; #1;
    check8("R9 takeover mixed", {5'b0, pwm_peci_zone}, 8'h05);
    replace_en = 1'b0; #1;
    check8("R9 takeover off", {5'b0, pwm_peci_zone}, 8'h00);
    pwm_behav = {3'b100, 3'b000, 3'b010};
    replace_en = 1'b1; #1;
    check8("R9 takeover middle only", {5'b0, pwm_peci_zone}, 8'h02);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule